// File: doc/BRIEF.md
# Instruction Constant Gather Unit

This unit sits in the early decode stages of a wide instruction bundle with up to eight flow slots. Each slot holds an op word plus a share of a chunk pool: extension chunks and literal-constant chunks of fixed width that the bundle lays out back to back in slot order. The op itself is never parsed here. Two small count fields at a fixed place in each op word say how many extension chunks and how many constant chunks belong to that op.

In the first cycle the unit latches the pool and the count fields, and it computes each slot's starting chunk index as a running sum of the counts of all lower slots. In the second cycle every slot selects its own chunks from the pool using that start index. The extension field and the constant value for each slot appear two cycles after the bundle is presented, so a dependent op in the following stage can consume the literal. A new bundle may be presented on every cycle.

Downstream decode uses the per-slot extension field to finish decoding each op. It uses the per-slot constant value, qualified by its valid bit, as the literal result of a constant-producing op.

Top module: `cgu_top`

## Requirements
- R1: Within each slot's op word, bits [1:0] give the extension-chunk count (0 to 3) and bits [3:2] give the constant-chunk count (0 to 3). The remaining op bits have no influence on any extracted field.
- R2: The chunk pool is 48 chunks of 47 bits each. Chunk k occupies bits [47k+46:47k] of the chunk input. Slot s owns a run of chunks that starts at the sum of the extension and constant counts of slots 0 to s-1. Within that run its extension chunks come first and its constant chunks follow.
- R3: Each slot's extension output is a 141-bit field. It holds the slot's first extension chunk in bits [46:0], the second in [93:47] and the third in [140:94]. Every position beyond the slot's extension count is zero.
- R4: Each slot's constant output is built the same way from its constant chunks: lowest chunk in the lowest bits, zero above the chunks it owns.
- R5: A slot's constant-valid bit is 1 exactly when the output bundle is valid and that slot's constant count is nonzero. A slot whose constant-valid bit is 0 in a valid bundle shows a constant output of zero.
- R6: The output valid equals the input valid from exactly two cycles earlier. Bundles presented on consecutive cycles emerge on consecutive cycles, in order.
- R7: While reset is held, the output valid and every constant-valid bit are 0 and the constant outputs are zero.
- R8: Pool chunks that no slot owns have no effect on any output.
- R9: Each slot's op word is delivered unchanged on the output alongside its extracted fields, with the same two-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle present on this cycle |
| in_ops | input | 256 | Eight 32-bit op words, slot s at bits [32s+31:32s] |
| in_chunks | input | 2256 | Chunk pool, 48 chunks of 47 bits |
| out_valid | output | 1 | Output bundle valid |
| out_ops | output | 256 | Op words aligned with the extracted fields |
| out_ext | output | 1128 | Eight 141-bit extension fields |
| out_con | output | 1128 | Eight 141-bit constant values |
| out_con_valid | output | 8 | Per-slot constant present |

## Verification
The bench builds the unit with its default parameters: eight slots, 47-bit chunks and 2-bit count fields, so the pool holds 48 chunks. With these values a bundle in which every slot claims three extension and three constant chunks fills the pool exactly to its last chunk. This makes the top of the running sum and the highest select index reachable. The same values make bundles with a lone busy top slot possible, as well as all-empty bundles and back-to-back random bundles with random unowned chunks and random op bits. A reference walk of the pool in the bench predicts every field.

// File: rtl/cgu_pkg.sv
package cgu_pkg;

    localparam int CGU_SLOTS   = 8;
    localparam int CGU_CHUNK_W = 47;
    localparam int CGU_OP_W    = 32;
    localparam int CGU_CNT_W   = 2;
    localparam int CGU_EXT_LSB = 0;
    localparam int CGU_CON_LSB = 2;
    localparam int CGU_MAX_PER = (1 << CGU_CNT_W) - 1;

    // Chunk counts read from the fixed header bits of one op word
    typedef struct packed {
        logic [CGU_CNT_W-1:0] con;
        logic [CGU_CNT_W-1:0] ext;
    } slot_cnt_t;

    // Number of pool chunks one slot consumes
    function automatic logic [CGU_CNT_W:0] slot_span(input slot_cnt_t c);
        return {1'b0, c.ext} + {1'b0, c.con};
    endfunction

endpackage

// File: rtl/cgu_count_scan.sv
module cgu_count_scan
    import cgu_pkg::*;
#(
    parameter int NUM_SLOTS = CGU_SLOTS,
    parameter int OFF_W     = 6
) (
    input  slot_cnt_t [NUM_SLOTS-1:0]            cnt,
    output logic      [NUM_SLOTS-1:0][OFF_W-1:0] base
);

    // Running sum: each slot starts where the slot below it ends
    assign base[0] = '0;

    for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_scan
        assign base[s] = base[s-1] + OFF_W'(slot_span(cnt[s-1]));
    end

endmodule

// File: rtl/cgu_field_gather.sv
module cgu_field_gather
    import cgu_pkg::*;
#(
    parameter int CHUNK_W = CGU_CHUNK_W,
    parameter int POOL    = 48,
    parameter int OFF_W   = 6,
    parameter int MAX_PER = CGU_MAX_PER,
    localparam int FIELD_W = MAX_PER * CHUNK_W
) (
    input  logic [CHUNK_W-1:0]   pool [POOL],
    input  logic [OFF_W-1:0]     start,
    input  logic [CGU_CNT_W-1:0] count,
    output logic [FIELD_W-1:0]   field
);

    for (genvar j = 0; j < MAX_PER; j++) begin : g_chunk
        logic [OFF_W:0] idx;
        logic           take;

        assign idx  = {1'b0, start} + (OFF_W+1)'(j);
        assign take = (CGU_CNT_W'(j) < count) && (idx < (OFF_W+1)'(POOL));
        assign field[j*CHUNK_W +: CHUNK_W] = take ? pool[idx[OFF_W-1:0]] : '0;
    end

endmodule

// File: rtl/cgu_slot_extract.sv
module cgu_slot_extract
    import cgu_pkg::*;
#(
    parameter int CHUNK_W = CGU_CHUNK_W,
    parameter int POOL    = 48,
    parameter int OFF_W   = 6,
    parameter int MAX_PER = CGU_MAX_PER,
    localparam int FIELD_W = MAX_PER * CHUNK_W
) (
    input  logic [CHUNK_W-1:0] pool [POOL],
    input  logic [OFF_W-1:0]   base,
    input  slot_cnt_t          cnt,
    output logic [FIELD_W-1:0] ext_field,
    output logic [FIELD_W-1:0] con_field,
    output logic               con_hit
);

    logic [OFF_W-1:0] con_start;

    // Constant chunks follow the slot's extension chunks
    assign con_start = base + OFF_W'(cnt.ext);
    assign con_hit   = (cnt.con != '0);

    cgu_field_gather #(
        .CHUNK_W (CHUNK_W),
        .POOL    (POOL),
        .OFF_W   (OFF_W),
        .MAX_PER (MAX_PER)
    ) u_ext (
        .pool  (pool),
        .start (base),
        .count (cnt.ext),
        .field (ext_field)
    );

    cgu_field_gather #(
        .CHUNK_W (CHUNK_W),
        .POOL    (POOL),
        .OFF_W   (OFF_W),
        .MAX_PER (MAX_PER)
    ) u_con (
        .pool  (pool),
        .start (con_start),
        .count (cnt.con),
        .field (con_field)
    );

endmodule

// File: rtl/cgu_top.sv
module cgu_top
    import cgu_pkg::*;
#(
    parameter int NUM_SLOTS = CGU_SLOTS,
    parameter int CHUNK_W   = CGU_CHUNK_W,
    parameter int OP_W      = CGU_OP_W,
    parameter int EXT_LSB   = CGU_EXT_LSB,
    parameter int CON_LSB   = CGU_CON_LSB
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       in_valid,
    input  logic [NUM_SLOTS*OP_W-1:0]                  in_ops,
    input  logic [NUM_SLOTS*2*CGU_MAX_PER*CHUNK_W-1:0] in_chunks,
    output logic                                       out_valid,
    output logic [NUM_SLOTS*OP_W-1:0]                  out_ops,
    output logic [NUM_SLOTS*CGU_MAX_PER*CHUNK_W-1:0]   out_ext,
    output logic [NUM_SLOTS*CGU_MAX_PER*CHUNK_W-1:0]   out_con,
    output logic [NUM_SLOTS-1:0]                       out_con_valid
);

    localparam int MAX_PER     = CGU_MAX_PER;
    localparam int SLOT_CHUNKS = 2 * MAX_PER;
    localparam int POOL        = NUM_SLOTS * SLOT_CHUNKS;
    localparam int OFF_W       = $clog2(POOL + 1);
    localparam int FIELD_W     = MAX_PER * CHUNK_W;

    // ---------------- stage A: pack pool, read counts, prefix sum ----------------
    slot_cnt_t [NUM_SLOTS-1:0]            cnt_d, cnt_q;
    logic      [NUM_SLOTS-1:0][OFF_W-1:0] base_d, base_q;
    logic      [CHUNK_W-1:0]              pool_d [POOL];
    logic      [CHUNK_W-1:0]              pool_q [POOL];
    logic      [NUM_SLOTS*OP_W-1:0]       ops_q;
    logic                                 va_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hdr
        assign cnt_d[s].ext = in_ops[s*OP_W + EXT_LSB +: CGU_CNT_W];
        assign cnt_d[s].con = in_ops[s*OP_W + CON_LSB +: CGU_CNT_W];
    end

    for (genvar c = 0; c < POOL; c++) begin : g_pack
        assign pool_d[c] = in_chunks[c*CHUNK_W +: CHUNK_W];
    end

    cgu_count_scan #(
        .NUM_SLOTS (NUM_SLOTS),
        .OFF_W     (OFF_W)
    ) u_scan (
        .cnt  (cnt_d),
        .base (base_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
            ops_q  <= '0;
            for (int k = 0; k < POOL; k++) begin
                pool_q[k] <= '0;
            end
        end else begin
            va_q <= in_valid;
            if (in_valid) begin
                cnt_q  <= cnt_d;
                base_q <= base_d;
                ops_q  <= in_ops;
                for (int k = 0; k < POOL; k++) begin
                    pool_q[k] <= pool_d[k];
                end
            end
        end
    end

    // ---------------- stage B: per-slot selection ----------------
    logic [NUM_SLOTS-1:0][FIELD_W-1:0] ext_f, con_f;
    logic [NUM_SLOTS-1:0]              hit;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        cgu_slot_extract #(
            .CHUNK_W (CHUNK_W),
            .POOL    (POOL),
            .OFF_W   (OFF_W),
            .MAX_PER (MAX_PER)
        ) u_slot (
            .pool      (pool_q),
            .base      (base_q[s]),
            .cnt       (cnt_q[s]),
            .ext_field (ext_f[s]),
            .con_field (con_f[s]),
            .con_hit   (hit[s])
        );
    end

    logic [NUM_SLOTS-1:0][FIELD_W-1:0] ext_q, con_q;
    logic [NUM_SLOTS-1:0]              cv_q;
    logic [NUM_SLOTS*OP_W-1:0]         ops_b_q;
    logic                              vb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q    <= 1'b0;
            cv_q    <= '0;
            ext_q   <= '0;
            con_q   <= '0;
            ops_b_q <= '0;
        end else begin
            vb_q <= va_q;
            cv_q <= va_q ? hit : '0;
            if (va_q) begin
                ext_q   <= ext_f;
                con_q   <= con_f;
                ops_b_q <= ops_q;
            end
        end
    end

    assign out_valid     = vb_q;
    assign out_con_valid = cv_q;
    assign out_ext       = ext_q;
    assign out_con       = con_q;
    assign out_ops       = ops_b_q;

endmodule

// File: rtl/cgu_checker.sv
module cgu_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int FIELD_W   = 141
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic                         out_valid,
    input logic [NUM_SLOTS*FIELD_W-1:0] out_con,
    input logic [NUM_SLOTS-1:0]         out_con_valid
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_con_valid == '0)); // R7

    AST_CON_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_con_valid == '0)); // R5

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_zero
        AST_CON_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_con_valid[s]) |-> (out_con[s*FIELD_W +: FIELD_W] == '0)); // R5
    end

endmodule

bind cgu_top cgu_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .FIELD_W   (FIELD_W)
) u_cgu_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .out_valid     (out_valid),
    .out_con       (out_con),
    .out_con_valid (out_con_valid)
);

// File: tb/sim_cgu_top.sv
`timescale 1ns/1ps
module sim_cgu_top;
    import cgu_pkg::*;

    localparam int SLOTS = CGU_SLOTS;
    localparam int CW    = CGU_CHUNK_W;
    localparam int OPW   = CGU_OP_W;
    localparam int MP    = 3;
    localparam int POOL  = SLOTS * 2 * MP;
    localparam int FW    = MP * CW;

    typedef struct packed {
        logic [SLOTS-1:0][OPW-1:0] ops;
        logic [SLOTS-1:0][FW-1:0]  ext;
        logic [SLOTS-1:0][FW-1:0]  con;
        logic [SLOTS-1:0]          cv;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic [SLOTS*OPW-1:0]  in_ops = '0;
    logic [POOL*CW-1:0]    in_chunks = '0;
    logic                  out_valid;
    logic [SLOTS*OPW-1:0]  out_ops;
    logic [SLOTS*FW-1:0]   out_ext;
    logic [SLOTS*FW-1:0]   out_con;
    logic [SLOTS-1:0]      out_con_valid;

    int errors = 0;
    int checks = 0;
    int ecnt [SLOTS];
    int ccnt [SLOTS];
    exp_t q[$];
    logic h0 = 1'b0;
    logic h1 = 1'b0;

    always #5 clk = ~clk;

    cgu_top u0 (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_ops        (in_ops),
        .in_chunks     (in_chunks),
        .out_valid     (out_valid),
        .out_ops       (out_ops),
        .out_ext       (out_ext),
        .out_con       (out_con),
        .out_con_valid (out_con_valid)
    );

    task automatic fill_random();
        for (int c = 0; c < POOL; c++) begin
            in_chunks[c*CW +: CW] = CW'({$urandom(), $urandom()});
        end
        for (int s = 0; s < SLOTS; s++) begin
            in_ops[s*OPW +: OPW] = $urandom();
        end
    endtask

    // Driver: present one bundle built from ecnt/ccnt and queue its reference result
    task automatic send();
        exp_t e;
        int   off;
        @(posedge clk);
        #2;
        fill_random();
        e   = '0;
        off = 0;
        for (int s = 0; s < SLOTS; s++) begin
            in_ops[s*OPW + 0 +: 2] = 2'(ecnt[s]);
            in_ops[s*OPW + 2 +: 2] = 2'(ccnt[s]);
            e.ops[s] = in_ops[s*OPW +: OPW];
            for (int j = 0; j < ecnt[s]; j++) begin
                e.ext[s][j*CW +: CW] = in_chunks[(off + j)*CW +: CW];
            end
            off += ecnt[s];
            for (int j = 0; j < ccnt[s]; j++) begin
                e.con[s][j*CW +: CW] = in_chunks[(off + j)*CW +: CW];
            end
            off += ccnt[s];
            e.cv[s] = (ccnt[s] != 0);
        end
        in_valid = 1'b1;
        q.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk);
        #2;
        fill_random();
        in_valid = 1'b0;
    endtask

    task automatic set_all(input int ev, input int cv);
        for (int s = 0; s < SLOTS; s++) begin
            ecnt[s] = ev;
            ccnt[s] = cv;
        end
    endtask

    // Monitor: checks valid timing and pops the scoreboard on every output bundle
    always @(negedge clk) begin
        if (rst) begin
            h0 = 1'b0;
            h1 = 1'b0;
        end else begin
            checks++;
            if (out_valid !== h1) begin
                errors++;
                $display("FAIL R6 out_valid actual=%b expected=%b", out_valid, h1);
            end
            if (out_valid === 1'b1) begin
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R6 unexpected bundle actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    for (int s = 0; s < SLOTS; s++) begin
                        checks += 4;
                        if (out_ext[s*FW +: FW] !== e.ext[s]) begin
                            errors++;
                            $display("FAIL R1 R2 R3 R8 slot %0d ext actual=%h expected=%h",
                                     s, out_ext[s*FW +: FW], e.ext[s]);
                        end
                        if (out_con[s*FW +: FW] !== e.con[s]) begin
                            errors++;
                            $display("FAIL R2 R4 R8 slot %0d con actual=%h expected=%h",
                                     s, out_con[s*FW +: FW], e.con[s]);
                        end
                        if (out_con_valid[s] !== e.cv[s]) begin
                            errors++;
                            $display("FAIL R5 slot %0d con_valid actual=%b expected=%b",
                                     s, out_con_valid[s], e.cv[s]);
                        end
                        if (out_ops[s*OPW +: OPW] !== e.ops[s]) begin
                            errors++;
                            $display("FAIL R9 slot %0d op actual=%h expected=%h",
                                     s, out_ops[s*OPW +: OPW], e.ops[s]);
                        end
                    end
                end
            end
            h1 = h0;
            h0 = in_valid;
        end
    end

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        fill_random();
        in_valid = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        // R7: outputs quiet while reset is held, despite active-looking inputs
        checks++;
        if (out_valid !== 1'b0 || out_con_valid !== '0 || out_con !== '0) begin
            errors++;
            $display("FAIL R7 reset state actual=%b/%h expected=0/0", out_valid, out_con_valid);
        end
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        rst = 1'b0;
        idle();
        idle();

        set_all(0, 0);   send();               // empty bundle: all zero, no constants
        set_all(3, 3);   send();               // full pool, last chunk owned
        set_all(0, 0);   ecnt[7] = 3; ccnt[7] = 3; send();  // only top slot busy
        set_all(0, 3);   send();               // constants only
        set_all(3, 0);   send();               // extensions only
        idle();
        set_all(1, 2);   send();
        idle();
        idle();
        set_all(2, 1);   ecnt[0] = 0; ccnt[0] = 0; send();

        for (int n = 0; n < 400; n++) begin
            if (($urandom() % 4) == 0) begin
                idle();
            end else begin
                for (int s = 0; s < SLOTS; s++) begin
                    ecnt[s] = int'($urandom() % 4);
                    ccnt[s] = int'($urandom() % 4);
                end
                send();
            end
        end

        repeat (6) idle();
        // R6: every presented bundle came out
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R6 pending bundles actual=%0d expected=0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule